// File: doc/BRIEF.md
# Scrambled NRZI Transmit Serializer

This block sits at the transmit end of a 100 Mb/s twisted-pair physical layer. A 4B/5B encoder hands it one 5-bit code-group per symbol period. The block whitens the bits with a key stream from an 11-stage recursive shift register and turns each whitened group into a serial bit stream, one bit per bit clock. The serial stream leaves the block NRZI-coded on a single line.

The block itself sets the symbol boundary. A take window, one bit clock wide, opens once every five bit clocks. The encoder presents a code-group with its load strobe during that window. If no strobe arrives in the window, the block sends an idle group in its place and raises an underrun flag. The key stream runs freely and steps once per bit, so every transmitted bit is whitened by its own key bit.

Top module: `scr_nrzi_tx`

## Requirements
- R1: While reset is asserted, and after its release until the first take window, `line_o`, `underrun_o` and `cg_take_o` are 0.
- R2: `cg_take_o` is high for exactly one bit clock in every five. It first rises four bit clocks after the slot counter and key stream leave reset together.
- R3: A code-group is captured only at the bit-clock edge that ends a cycle with `cg_take_o` high and `cg_load_i` high. The values of `cg_load_i` and `cg_data_i` in any other cycle have no effect on `line_o`.
- R4: The group captured at edge L goes out with bit [4] first. Its bits drive the line at edges L+1 to L+5, in the order [4], [3], [2], [1], [0].
- R5: The key state s[10:0] holds X[n-1] in s[0] and X[n-11] in s[10]. It is seeded with the nonzero parameter SEED and steps at every bit clock. Each step produces X[n] = s[10] XOR s[8] and shifts it into s[0]. Group bit [4-j] is XORed with the key bit produced at edge L+j, for j from 0 to 4, before serialization.
- R6: Each whitened bit is NRZI-coded at its edge: a 1 toggles `line_o` and a 0 leaves it unchanged.
- R7: If `cg_load_i` is low during a take window, the idle group 11111 is whitened and sent in place of a code-group. `underrun_o` is then high for the single bit clock that follows.
- R8: Asserting `rst_ni` clears `line_o` at once, without waiting for a clock edge. After release, the key stream restarts from SEED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cg_data_i | input | 5 | Code-group from the encoder |
| cg_load_i | input | 1 | Load strobe, sampled only in the take window |
| cg_take_o | output | 1 | Take window, high one cycle in five |
| underrun_o | output | 1 | One-cycle pulse after a take window without a strobe |
| line_o | output | 1 | NRZI serial line level |

## Verification
A wrong key state, whether stuck, stepped at the wrong rate or off by one phase, changes the whitened bits. It therefore shows up on `line_o` within the first group after the take window at the latest, as a missing or extra transition. A slot counter that slips shows up at `cg_take_o` within five bit clocks. It also shifts group bits across the boundary, which corrupts `line_o` in the next group. A shift register that sends the bits in the wrong order, or a line register that fails to toggle, changes the line within one to five bit clocks of a capture. A bench model that steps the key stream from SEED, and is aligned to the first take window, therefore compares every line bit.

// File: rtl/scr_tx_pkg.sv
package scr_tx_pkg;
  localparam int unsigned CG_W    = 5;
  localparam int unsigned KEY_W   = 11;
  localparam int unsigned KEY_TAP = 9;
  localparam logic [CG_W-1:0] CG_IDLE = '1;
  typedef logic [CG_W-1:0] cg_t;
endpackage

// File: rtl/scr_tx_rstsync.sv
module scr_tx_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/scr_tx_keygen.sv
module scr_tx_keygen #(
  parameter int unsigned W     = 11,
  parameter int unsigned TAP   = 9,
  parameter int unsigned OUT_W = 5,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] key_o
);
  logic [W-1:0] state_q, state_d;

  // next OUT_W key bits, first-produced bit in the MSB
  function automatic logic [OUT_W-1:0] lookahead(input logic [W-1:0] s);
    logic [W-1:0]     t;
    logic             b;
    logic [OUT_W-1:0] r;
    t = s;
    r = '0;
    for (int j = 0; j < OUT_W; j++) begin
      b = t[W-1] ^ t[TAP-1];
      r[OUT_W-1-j] = b;
      t = {t[W-2:0], b};
    end
    return r;
  endfunction

  always_comb begin
    state_d = {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign key_o = lookahead(state_q);

  AST_KEY_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R5
  AST_KEY_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R5
endmodule

// File: rtl/scr_tx_slot.sv
module scr_tx_slot #(
  parameter int unsigned CG_W = 5,
  parameter logic [CG_W-1:0] IDLE = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CG_W-1:0] data_i,
  output logic            take_o,
  output logic [CG_W-1:0] group_o,
  output logic            underrun_o
);
  localparam int unsigned CNT_W = $clog2(CG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CG_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             und_q, und_d;

  assign take_o = (cnt_q == LAST);

  always_comb begin
    cnt_d   = take_o ? '0 : cnt_q + CNT_W'(1);
    und_d   = take_o & ~load_i;
    group_o = load_i ? data_i : IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      und_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      und_q <= und_d;
    end
  end

  assign underrun_o = und_q;

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_TAKE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R2
  AST_UNDERRUN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> cnt_q == '0); // R7
endmodule

// File: rtl/scr_tx_piso.sv
module scr_tx_piso #(
  parameter int unsigned CG_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CG_W-1:0] par_i,
  output logic            line_o
);
  logic [CG_W-1:0] sh_q, sh_d, shifted;
  logic            line_q, line_d;

  for (genvar i = 0; i < CG_W; i++) begin : g_shift
    if (i == 0) begin : g_lsb
      assign shifted[i] = 1'b0;
    end else begin : g_mid
      assign shifted[i] = sh_q[i-1];
    end
  end

  always_comb begin
    sh_d   = load_i ? par_i : shifted;
    line_d = line_q ^ sh_q[CG_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      line_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

  AST_SHIFT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> sh_q[0] == 1'b0); // R4
endmodule

// File: rtl/scr_nrzi_tx.sv
module scr_nrzi_tx
  import scr_tx_pkg::*;
#(
  parameter logic [KEY_W-1:0] SEED = 11'h7FF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [CG_W-1:0] cg_data_i,
  input  logic            cg_load_i,
  output logic            cg_take_o,
  output logic            underrun_o,
  output logic            line_o
);
  logic rst_sync_n;
  cg_t  key, group, whitened;
  logic take;

  scr_tx_rstsync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_sync_n)
  );

  scr_tx_keygen #(.W(KEY_W), .TAP(KEY_TAP), .OUT_W(CG_W), .SEED(SEED)) u_key (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .key_o (key)
  );

  scr_tx_slot #(.CG_W(CG_W), .IDLE(CG_IDLE)) u_slot (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .load_i (cg_load_i),
    .data_i (cg_data_i), .take_o (take), .group_o (group),
    .underrun_o (underrun_o)
  );

  assign whitened = group ^ key;

  scr_tx_piso #(.CG_W(CG_W)) u_piso (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .load_i (take),
    .par_i (whitened), .line_o (line_o)
  );

  assign cg_take_o = take;

  AST_UNDERRUN_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    underrun_o |-> !cg_take_o); // R7
endmodule

// File: tb/tb_scr_nrzi_tx.sv
module tb_scr_nrzi_tx;
  localparam logic [10:0] SEED = 11'h2C5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] cg_data;
  logic       cg_load;
  logic       cg_take, underrun, line_out;

  scr_nrzi_tx #(.SEED(SEED)) dut (
    .clk_i (clk), .rst_ni (rst_n), .cg_data_i (cg_data), .cg_load_i (cg_load),
    .cg_take_o (cg_take), .underrun_o (underrun), .line_o (line_out)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [10:0] mk;
  logic [2:0]  mc;
  logic [4:0]  ms;
  logic        ml, mu;

  // {load, data}
  localparam logic [5:0] VEC [16] = '{
    6'b1_00000, 6'b1_11111, 6'b1_10000, 6'b1_00001,
    6'b0_10101, 6'b1_01010, 6'b1_11000, 6'b0_00000,
    6'b0_11111, 6'b1_00111, 6'b1_10110, 6'b1_01101,
    6'b1_00000, 6'b1_00000, 6'b1_11110, 6'b1_01111
  };

  function automatic logic [10:0] kstep(input logic [10:0] s);
    return {s[9:0], s[10] ^ s[8]};
  endfunction

  function automatic logic [4:0] key5(input logic [10:0] s);
    logic [10:0] t;
    logic [4:0]  r;
    t = s;
    for (int j = 0; j < 5; j++) begin
      r[4-j] = t[10] ^ t[8];
      t = kstep(t);
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic ld, input logic [4:0] d);
    logic t;
    t = (mc == 3'd4);
    cg_load = ld;
    cg_data = d;
    @(posedge clk);
    ml = ml ^ ms[4];
    if (t) ms = (ld ? d : 5'b11111) ^ key5(mk);
    else   ms = {ms[3:0], 1'b0};
    mu = t & ~ld;
    mc = t ? 3'd0 : mc + 3'd1;
    mk = kstep(mk);
    @(negedge clk);
    chk("R3 R4 R5 R6 line", line_out, ml);
    chk("R2 take window", cg_take, (mc == 3'd4));
    chk("R7 underrun", underrun, mu);
  endtask

  task automatic sync_up();
    int n;
    n = 0;
    cg_load = 1'b0;
    cg_data = 5'b0;
    while (cg_take !== 1'b1 && n < 20) begin
      chk("R1 line before first window", line_out, 0);
      chk("R1 underrun before first window", underrun, 0);
      @(negedge clk);
      n++;
    end
    chk("R2 first window seen", cg_take, 1);
    chk("R1 line at first window", line_out, 0);
    mk = SEED;
    for (int i = 0; i < 4; i++) mk = kstep(mk);
    mc = 3'd4;
    ms = 5'b0;
    ml = 1'b0;
    mu = 1'b0;
  endtask

  task automatic run_vec(input int count);
    for (int i = 0; i < count; i++) begin
      while (mc != 3'd4) tick(1'b1, ~VEC[i][4:0]);  // R3 loads outside window
      tick(VEC[i][5], VEC[i][4:0]);
    end
    for (int i = 0; i < 5; i++) tick(1'b0, 5'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int toggles;
    logic prev;
    int n;
    rst_n   = 1'b0;
    cg_load = 1'b0;
    cg_data = 5'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset line", line_out, 0);
      chk("R1 reset take", cg_take, 0);
      chk("R1 reset underrun", underrun, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    sync_up();
    run_vec(16);

    // R5: all-zero data still yields transitions from a nonzero key stream
    toggles = 0;
    prev = line_out;
    for (int i = 0; i < 60; i++) begin
      tick(mc == 3'd4, 5'b0);
      if (line_out != prev) toggles++;
      prev = line_out;
    end
    chk("R5 key stream not locked", (toggles > 0), 1);

    // R8: asynchronous clear while the line is high
    n = 0;
    while (line_out !== 1'b1 && n < 40) begin
      tick(mc == 3'd4, 5'b10101);
      n++;
    end
    chk("R8 line high before reset", line_out, 1);
    #3 rst_n = 1'b0;
    #1 chk("R8 async clear of line", line_out, 0);
    chk("R1 take cleared in reset", cg_take, 0);
    chk("R1 underrun cleared in reset", underrun, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sync_up();
    run_vec(8);  // R8 key stream restarted from SEED

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule